// File: doc/BRIEF.md
# Two-Stage Correction Output Scheduler

This block sequences the output side of a receiver that protects its data with a two-dimensional product code. Each received block is 272 bits long and carries a (272,190) row code. A row decoder outside this block corrects each block and reports one status bit per block: corrected or not. The scheduler forwards every row-corrected block at once, with its position in the frame. Parity blocks are forwarded too. While the frame arrives, the block records whether any row failed and whether frame sync held for the whole frame.

A frame is 272 blocks. After the last block of a frame is accepted, the scheduler decides whether a column pass is worth running. The column pass runs only when sync held throughout the frame and at least one row failed. In that case it issues a one-cycle request to the column decoder and waits for its done handshake. In every case it then emits the 190 data-block indices of the frame, never the parity blocks, on a second stream. A flag on that stream tells whether the data went through the column pass or is the row-corrected data unchanged.

The block handles only sequencing. It carries indices and flags, not block payloads, so the data buffer and both decoders stay outside it.

Top module: `corr_out_sched`

## Requirements
- R1: Each block accepted with `in_valid` high appears on the row stream on the next cycle, with `row_valid` high. `row_idx` counts 0 to 271 over the accepted blocks of a frame and returns to 0 after 271. Cycles with `in_valid` low produce no row output and do not advance the index.
- R2: `row_parity` is 1 exactly when `row_idx` is 190 or more. Indices 0 to 189 are data blocks and 190 to 271 are parity blocks.
- R3: While `rst_n` is low, every output is 0.
- R4: `col_req` is a pulse one cycle wide. It rises on the second cycle after the edge that accepts block 271, and only when that frame both had a failure and kept sync.
- R5: A frame has a failure when any of its accepted blocks had `in_ok` low. A frame kept sync when `in_sync` was high on every one of its accepted blocks. Losing sync on a single block cancels the request for that frame.
- R6: A frame whose blocks all had `in_ok` high raises no `col_req`.
- R7: Each frame produces exactly 190 consecutive `col_valid` cycles with `col_idx` 0, 1, … 189. Parity indices never appear on this stream.
- R8: When no column pass runs, the column stream starts in the cycle in which `col_req` would have appeared, with `col_fixed` = 0. When a pass runs, the stream starts the cycle after `col_done` is sampled high, with `col_fixed` = 1.
- R9: `col_done` has no effect unless the block is waiting for a requested column pass.
- R10: The failure and sync records start fresh with every frame, so the decision for a frame ignores the blocks of earlier frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A row-decoded block is presented this cycle |
| in_ok | input | 1 | The presented block was fully corrected by the row decoder |
| in_sync | input | 1 | Frame sync is currently achieved |
| col_done | input | 1 | The column decoder has finished the requested pass |
| row_valid | output | 1 | Row stream block valid |
| row_idx | output | 9 | Position of the row stream block in its frame |
| row_parity | output | 1 | Row stream block is a parity block |
| col_req | output | 1 | One-cycle request to start a column pass |
| col_valid | output | 1 | Column stream block valid |
| col_idx | output | 9 | Data-block index on the column stream |
| col_fixed | output | 1 | Column stream data went through the column pass |

## Verification
The assertions take two things for granted about the environment. First, `col_done` answers a request before the next frame completes. Second, a new frame does not finish while the previous frame's column stream is still running. The bench inserts random idle gaps between blocks, but every frame still takes at least 272 cycles. It answers each request within 40 cycles, so one frame is always drained before the next one ends. It also raises `col_done` when nothing is waiting, which checks that this stray handshake has no effect.

// File: rtl/corr_out_sched_pkg.sv
// Package: shared types for the correction output scheduler.
// Assumes nothing beyond being compiled before the modules that import it.
package corr_out_sched_pkg;

    // State of the column-output sequencer
    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_WAIT   = 2'd1,
        SEQ_STREAM = 2'd2
    } seq_state_t;

endpackage

// File: rtl/cos_frame_tracker.sv
// Module: cos_frame_tracker
// Tracks the position of each accepted block within the frame.
// Forwards every block on the row stream one cycle later.
// Keeps two sticky records over the frame: a row failure was seen, and sync
// was lost. At the last block it emits a one-cycle frame-end pulse together
// with the column-pass decision.
// Assumes in_ok and in_sync are meaningful only while in_valid is high.
module cos_frame_tracker #(
    parameter int FRAME_BLKS = 272,
    parameter int DATA_BLKS  = 190,
    parameter int IDX_W      = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_ok,
    input  logic             in_sync,
    output logic             row_valid,
    output logic [IDX_W-1:0] row_idx,
    output logic             row_parity,
    output logic             frame_end,
    output logic             frame_run_col
);

    localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(FRAME_BLKS - 1);
    localparam logic [IDX_W-1:0] FIRST_PAR = IDX_W'(DATA_BLKS);

    logic [IDX_W-1:0] blk_cnt;
    logic             fail_seen;
    logic             sync_lost;
    logic             fail_now;
    logic             lost_now;

    // Sticky records, including the block being accepted now
    always_comb begin
        fail_now = fail_seen | ~in_ok;
        lost_now = sync_lost | ~in_sync;
    end

    // Block counter and sticky records; both clear when a frame completes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_cnt   <= '0;
            fail_seen <= 1'b0;
            sync_lost <= 1'b0;
        end else if (in_valid) begin
            if (blk_cnt == LAST_IDX) begin
                blk_cnt   <= '0;
                fail_seen <= 1'b0;
                sync_lost <= 1'b0;
            end else begin
                blk_cnt   <= blk_cnt + 1'b1;
                fail_seen <= fail_now;
                sync_lost <= lost_now;
            end
        end
    end

    // Row stream register: passes each accepted block straight on
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_valid  <= 1'b0;
            row_idx    <= '0;
            row_parity <= 1'b0;
        end else begin
            row_valid <= in_valid;
            if (in_valid) begin
                row_idx    <= blk_cnt;
                row_parity <= (blk_cnt >= FIRST_PAR);
            end
        end
    end

    // Frame-end pulse and column-pass decision
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_end     <= 1'b0;
            frame_run_col <= 1'b0;
        end else begin
            frame_end <= in_valid && (blk_cnt == LAST_IDX);
            if (in_valid && (blk_cnt == LAST_IDX)) begin
                frame_run_col <= fail_now & ~lost_now;
            end
        end
    end

endmodule

// File: rtl/cos_col_sequencer.sv
// Module: cos_col_sequencer
// Reacts to each frame-end pulse. If the column pass is wanted, it pulses the
// request and waits for the done handshake; otherwise it skips the wait.
// It then streams the data-block indices 0..DATA_BLKS-1.
// Assumes a frame-end pulse never arrives while it is waiting or streaming.
module cos_col_sequencer
    import corr_out_sched_pkg::*;
#(
    parameter int DATA_BLKS = 190,
    parameter int IDX_W     = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_end,
    input  logic             frame_run_col,
    input  logic             col_done,
    output logic             col_req,
    output logic             col_valid,
    output logic [IDX_W-1:0] col_idx,
    output logic             col_fixed
);

    localparam logic [IDX_W-1:0] LAST_DATA = IDX_W'(DATA_BLKS - 1);

    seq_state_t state;

    // Sequencer state, request pulse and column stream registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SEQ_IDLE;
            col_req   <= 1'b0;
            col_valid <= 1'b0;
            col_idx   <= '0;
            col_fixed <= 1'b0;
        end else begin
            col_req <= 1'b0;
            case (state)
                SEQ_IDLE: begin
                    col_valid <= 1'b0;
                    if (frame_end) begin
                        if (frame_run_col) begin
                            state   <= SEQ_WAIT;
                            col_req <= 1'b1;
                        end else begin
                            state     <= SEQ_STREAM;
                            col_valid <= 1'b1;
                            col_idx   <= '0;
                            col_fixed <= 1'b0;
                        end
                    end
                end
                SEQ_WAIT: begin
                    col_valid <= 1'b0;
                    if (col_done) begin
                        state     <= SEQ_STREAM;
                        col_valid <= 1'b1;
                        col_idx   <= '0;
                        col_fixed <= 1'b1;
                    end
                end
                SEQ_STREAM: begin
                    if (col_idx == LAST_DATA) begin
                        state     <= SEQ_IDLE;
                        col_valid <= 1'b0;
                    end else begin
                        col_idx <= col_idx + 1'b1;
                    end
                end
                default: begin
                    state     <= SEQ_IDLE;
                    col_valid <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/corr_out_sched.sv
// Module: corr_out_sched (top)
// Two-stage correction output scheduler.
// The frame tracker handles the row stream and the per-frame decision.
// The column sequencer handles the request/done handshake and the stream of
// data-block indices.
// Assumes FRAME_BLKS > DATA_BLKS, and that the column stream of one frame
// drains before the next frame completes.
module corr_out_sched #(
    parameter int FRAME_BLKS = 272,
    parameter int DATA_BLKS  = 190,
    parameter int IDX_W      = $clog2(FRAME_BLKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_ok,
    input  logic             in_sync,
    input  logic             col_done,
    output logic             row_valid,
    output logic [IDX_W-1:0] row_idx,
    output logic             row_parity,
    output logic             col_req,
    output logic             col_valid,
    output logic [IDX_W-1:0] col_idx,
    output logic             col_fixed
);

    logic frame_end;
    logic frame_run_col;

    // Per-block tracking and row stream
    cos_frame_tracker #(
        .FRAME_BLKS (FRAME_BLKS),
        .DATA_BLKS  (DATA_BLKS),
        .IDX_W      (IDX_W)
    ) u_tracker (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .in_ok         (in_ok),
        .in_sync       (in_sync),
        .row_valid     (row_valid),
        .row_idx       (row_idx),
        .row_parity    (row_parity),
        .frame_end     (frame_end),
        .frame_run_col (frame_run_col)
    );

    // Column pass handshake and data-only stream
    cos_col_sequencer #(
        .DATA_BLKS (DATA_BLKS),
        .IDX_W     (IDX_W)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_end     (frame_end),
        .frame_run_col (frame_run_col),
        .col_done      (col_done),
        .col_req       (col_req),
        .col_valid     (col_valid),
        .col_idx       (col_idx),
        .col_fixed     (col_fixed)
    );

endmodule

// File: rtl/corr_out_sched_checker.sv
// Module: corr_out_sched_checker
// Temporal checks on the scheduler's ports, attached to every instance of the
// top module by the bind statement at the end of this file.
// Assumes the environment limits described for the top module.
module corr_out_sched_checker #(
    parameter int FRAME_BLKS = 272,
    parameter int DATA_BLKS  = 190,
    parameter int IDX_W      = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             row_valid,
    input logic [IDX_W-1:0] row_idx,
    input logic             row_parity,
    input logic             col_req,
    input logic             col_valid,
    input logic [IDX_W-1:0] col_idx
);

    logic [IDX_W-1:0] next_row;

    // Index expected for the next row-stream block
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_row <= '0;
        end else if (row_valid) begin
            next_row <= (row_idx == IDX_W'(FRAME_BLKS - 1)) ? '0 : row_idx + 1'b1;
        end
    end

    assert_row_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> row_valid);

    assert_row_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
        row_valid |-> row_idx == next_row);

    assert_parity_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (row_valid && row_parity) |-> row_idx >= IDX_W'(DATA_BLKS));

    assert_req_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        col_req |=> !col_req);

    assert_req_not_streaming_R8: assert property (@(posedge clk) disable iff (!rst_n)
        col_req |=> !col_valid);

    assert_col_data_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        col_valid |-> col_idx < IDX_W'(DATA_BLKS));

    assert_col_starts_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(col_valid) |-> col_idx == '0);

    assert_col_consecutive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && $past(col_valid)) |-> col_idx == $past(col_idx) + 1'b1);

endmodule

bind corr_out_sched corr_out_sched_checker #(
    .FRAME_BLKS (FRAME_BLKS),
    .DATA_BLKS  (DATA_BLKS),
    .IDX_W      (IDX_W)
) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .row_valid  (row_valid),
    .row_idx    (row_idx),
    .row_parity (row_parity),
    .col_req    (col_req),
    .col_valid  (col_valid),
    .col_idx    (col_idx)
);

// File: tb/tb_corr_out_sched.sv
// Bench for corr_out_sched: random gaps, failures and sync patterns mixed with
// directed frames, compared every cycle against a model built from the
// requirements.
module tb_corr_out_sched;

    localparam int FRAME = 272;
    localparam int DATA  = 190;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0, in_ok = 1'b0, in_sync = 1'b0, col_done = 1'b0;
    logic       row_valid, row_parity, col_req, col_valid, col_fixed;
    logic [8:0] row_idx, col_idx;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    corr_out_sched dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ok(in_ok),
        .in_sync(in_sync), .col_done(col_done), .row_valid(row_valid),
        .row_idx(row_idx), .row_parity(row_parity), .col_req(col_req),
        .col_valid(col_valid), .col_idx(col_idx), .col_fixed(col_fixed)
    );

    // Model state
    int m_cnt = 0, m_state = 0, m_cidx = 0;
    bit m_fail = 0, m_lost = 0, m_end = 0, m_run = 0, m_fixed = 0;
    bit e_rv = 0, e_req = 0, e_cv = 0;
    int e_ridx = 0;
    int req_count = 0, col_count = 0, done_cd = 0;
    bit spur = 0;

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit is_parity(input int idx);
        return idx >= DATA;
    endfunction

    // Advance the model over one clock edge and compare the outputs
    task automatic step();
        bit n_end, n_run;
        @(negedge clk);
        e_req = 0;
        case (m_state)
            0: begin
                e_cv = 0;
                if (m_end) begin
                    if (m_run) begin m_state = 1; e_req = 1; end
                    else begin m_state = 2; m_cidx = 0; m_fixed = 0; e_cv = 1; end
                end
            end
            1: if (col_done) begin m_state = 2; m_cidx = 0; m_fixed = 1; e_cv = 1; end
            default: begin
                if (m_cidx == DATA - 1) begin m_state = 0; e_cv = 0; end
                else m_cidx++;
            end
        endcase
        n_end = 0; n_run = m_run;
        e_rv = in_valid;
        if (in_valid) begin
            e_ridx = m_cnt;
            if (m_cnt == FRAME - 1) begin
                n_end = 1;
                n_run = (m_fail | ~in_ok) & ~(m_lost | ~in_sync);
                m_cnt = 0; m_fail = 0; m_lost = 0;
            end else begin
                m_cnt++;
                m_fail = m_fail | ~in_ok;
                m_lost = m_lost | ~in_sync;
            end
        end
        m_end = n_end; m_run = n_run;
        chk(row_valid, e_rv, "R1 row_valid");
        if (e_rv) begin
            chk(row_idx, e_ridx, "R1 row_idx");
            chk(row_parity, is_parity(e_ridx), "R2 row_parity");
        end
        chk(col_req, e_req, "R4 col_req");
        chk(col_valid, e_cv, "R7 col_valid");
        if (e_cv) begin
            chk(col_idx, m_cidx, "R7 col_idx");
            chk(col_fixed, m_fixed, "R8 col_fixed");
            col_count++;
        end
        if (col_req) req_count++;
    endtask

    // One cycle of stimulus, including the done handshake
    task automatic cyc(input bit v, input bit ok, input bit s);
        in_valid = v; in_ok = ok; in_sync = s;
        col_done = 0;
        if (done_cd > 0) begin
            done_cd--;
            if (done_cd == 0) col_done = 1;
        end else if (spur) begin
            col_done = 1;
        end
        step();
        if (col_req) done_cd = 1 + int'($urandom % 40);
    endtask

    // fmode: 0 none, 1 one failure at fpos, 2 random; smode: 0 held, 1 lost at spos, 2 absent
    task automatic send_frame(input int fmode, input int fpos, input int smode, input int spos);
        for (int i = 0; i < FRAME; i++) begin
            bit ok, s;
            while ($urandom % 4 == 0) cyc(0, 1'($urandom), 1'($urandom));
            ok = (fmode == 0) ? 1'b1 : (fmode == 1) ? (i != fpos) : ($urandom % 20 != 0);
            s  = (smode == 0) ? 1'b1 : (smode == 1) ? (i != spos) : 1'b0;
            cyc(1, ok, s);
        end
    endtask

    task automatic drain();
        for (int i = 0; i < 300; i++) cyc(0, 0, 0);
    endtask

    initial begin
        int r0;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R3: reset state
        chk(row_valid, 0, "R3 row_valid");
        chk(col_req, 0, "R3 col_req");
        chk(col_valid, 0, "R3 col_valid");
        chk(row_idx, 0, "R3 row_idx");
        chk(col_idx, 0, "R3 col_idx");
        rst_n = 1;

        // R9: stray done while idle
        spur = 1;
        for (int i = 0; i < 10; i++) cyc(0, 0, 0);
        spur = 0;
        chk(col_count, 0, "R9 stray done made no stream");

        // R6: clean frame, no request, unfixed data stream
        r0 = req_count; col_count = 0;
        send_frame(0, 0, 0, 0); drain();
        chk(req_count - r0, 0, "R6 no request on clean frame");
        chk(col_count, DATA, "R7 data blocks per frame");

        // R4: single failure with sync held
        r0 = req_count; col_count = 0;
        send_frame(1, 271, 0, 0); drain();
        chk(req_count - r0, 1, "R4 request on failing frame");
        chk(col_count, DATA, "R8 stream after done");

        // R5: failure but sync lost on one block
        r0 = req_count;
        send_frame(1, 3, 1, 150); drain();
        chk(req_count - r0, 0, "R5 sync loss cancels request");

        // R5: sync absent throughout
        r0 = req_count;
        send_frame(2, 0, 2, 0); drain();
        chk(req_count - r0, 0, "R5 no sync no request");

        // R10: clean frame after failing frame
        send_frame(1, 0, 0, 0);
        r0 = req_count + 1;
        send_frame(0, 0, 0, 0); drain();
        chk(req_count, r0, "R10 records restart each frame");

        // R9: stray done during a stream; frames back to back
        spur = 1;
        send_frame(0, 0, 0, 0);
        for (int i = 0; i < 100; i++) cyc(0, 0, 0);
        spur = 0;
        drain();

        // Random frames
        for (int f = 0; f < 6; f++) begin
            send_frame(int'($urandom % 3), int'($urandom % FRAME),
                       int'($urandom % 2), int'($urandom % FRAME));
        end
        drain();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule